// File: doc/BRIEF.md
# Ethernet PAUSE frame receiver

This block sits on the receive byte stream of a full-duplex Ethernet MAC and looks for MAC control frames that ask the link partner to stop sending. When such a frame arrives intact, the block reads the requested hold-off time. It then runs a timer that keeps the local transmitter from starting new frames until the time has run out. The time is counted in slot times of 128 transmit clock cycles. The block runs on the transmit clock, and the receive stream is assumed to have been brought into that domain already.

For every recognised frame the block gives a one-cycle notification. It also gives a drop flag, which tells the receive buffer logic whether to throw the frame away or keep it. The receive flow enable decides whether a recognised frame stops the transmitter. The pass-all control decides whether the frame is kept.

Top module: `flow_pause_unit`

## Requirements
- R1: A frame is recognised only when bytes 0..5 are 01 80 C2 00 00 01, bytes 12..13 are 88 08 and bytes 14..15 are 00 01. A frame with any of these bytes different gives no notification, no drop and no hold.
- R2: The hold-off value is formed from bytes 16 (high byte) and 17 (low byte). For an accepted frame with flow enable set, `tx_hold` rises one cycle after `ctrl_rx_pulse` and stays high for exactly value × 128 cycles.
- R3: When `flow_en` is low at the end-of-frame byte, a recognised frame still gives `ctrl_rx_pulse` but leaves `tx_hold` low.
- R4: `tx_hold` is a registered output. It is high exactly while the hold timer is nonzero, and the timer never wraps below zero.
- R5: A frame whose `rx_crc_ok` is low on its end-of-frame byte changes nothing: no notification, no drop and no hold.
- R6: A frame shorter than 64 bytes, counting the CRC, changes nothing. Longer frames with a matching header are accepted.
- R7: `ctrl_rx_pulse` is high for one cycle, in the cycle after the end-of-frame byte of an accepted frame, whatever the state of `flow_en`.
- R8: `frame_discard` is high together with `ctrl_rx_pulse` when `pass_all` was low at the end-of-frame byte. When `pass_all` was high it stays low. It is never high for other frames.
- R9: An accepted frame that arrives while the hold is running reloads the timer. The hold then lasts value × 128 cycles counted from the reload.
- R10: An accepted frame carrying the value zero ends a running hold: `tx_hold` is low one cycle after its `ctrl_rx_pulse`.
- R11: After reset `tx_hold`, `ctrl_rx_pulse` and `frame_discard` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame (last CRC byte) |
| rx_byte | input | 8 | Receive data byte |
| rx_crc_ok | input | 1 | CRC good, sampled with the end-of-frame byte |
| flow_en | input | 1 | Receive flow enable: accepted frames start a hold |
| pass_all | input | 1 | Keep control frames in the receive buffer |
| tx_hold | output | 1 | Transmitter must not start a new frame |
| ctrl_rx_pulse | output | 1 | One-cycle notice of an accepted control frame |
| frame_discard | output | 1 | Drop the frame just ended |

## Verification
Let the end-of-frame byte be sampled at clock edge k. The notification and the drop flag are then due in the cycle after edge k. A monitor reads them on the falling edge that follows and compares them with the next entry in the expected queue. `tx_hold` is registered one stage later, so it is first checked one falling edge after that, at edge k+1. From there the bench counts the falling edges during which `tx_hold` stays high and compares the count with value × 128. A reload or a cancel is checked in the same way, with edge k taken from the end of the frame that carries the new value.

// File: rtl/flow_pause_pkg.sv
// Shared constants for the PAUSE receiver: header match bytes and field sizes.
// Assumes the header is checked byte by byte in arrival order.
package flow_pause_pkg;
    localparam int QUANTA_W = 16;
    localparam int HDR_LEN  = 16;
    localparam int VAL_HI   = 16;
    localparam int VAL_LO   = 17;

    // Expected byte at a header offset (destination, type, opcode); the
    // source address (offsets 6..11) matches anything.
    function automatic logic [8:0] hdr_byte(input int idx);
        logic [8:0] r;
        case (idx)
            0:  r = {1'b1, 8'h01};
            1:  r = {1'b1, 8'h80};
            2:  r = {1'b1, 8'hC2};
            3:  r = {1'b1, 8'h00};
            4:  r = {1'b1, 8'h00};
            5:  r = {1'b1, 8'h01};
            12: r = {1'b1, 8'h88};
            13: r = {1'b1, 8'h08};
            14: r = {1'b1, 8'h00};
            15: r = {1'b1, 8'h01};
            default: r = {1'b0, 8'h00};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pause_frame_parser.sv
// Parses the receive byte stream, checks the control header, captures the
// hold-off value and at end of frame registers the accept decision.
// Assumes rx_sof and rx_eof come with rx_valid and that eof marks the last
// CRC byte; bytes outside a frame are ignored.
module pause_frame_parser
    import flow_pause_pkg::*;
#(
    parameter int MIN_FRAME = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic                rx_sof,
    input  logic                rx_eof,
    input  logic [7:0]          rx_byte,
    input  logic                rx_crc_ok,
    input  logic                flow_en,
    input  logic                pass_all,
    output logic                ctrl_pulse_q,
    output logic                drop_q,
    output logic                load_q,
    output logic [QUANTA_W-1:0] value_q
);
    localparam int IW = $clog2(MIN_FRAME + 1);

    logic [IW-1:0]       idx_q;
    logic [IW-1:0]       cur_idx;
    logic                in_frame_q;
    logic                match_q;
    logic                match_n;
    logic                byte_ok;
    logic                active;
    logic                long_enough;
    logic                accept;
    logic [8:0]          want;
    logic [QUANTA_W-1:0] val_acc_q;
    logic [QUANTA_W-1:0] val_n;

    // Per-byte decode: index, header compare, value capture, accept.
    always_comb begin
        active      = rx_valid && (rx_sof || in_frame_q);
        cur_idx     = rx_sof ? '0 : idx_q;
        want        = hdr_byte(int'(cur_idx));
        byte_ok     = (int'(cur_idx) >= HDR_LEN) || !want[8] || (rx_byte == want[7:0]);
        match_n     = (rx_sof || match_q) && byte_ok;
        val_n       = val_acc_q;
        if (int'(cur_idx) == VAL_HI) val_n = {rx_byte, val_acc_q[7:0]};
        if (int'(cur_idx) == VAL_LO) val_n = {val_acc_q[15:8], rx_byte};
        long_enough = int'(cur_idx) >= (MIN_FRAME - 1);
        accept      = active && rx_eof && match_n && long_enough && rx_crc_ok;
    end

    // Frame tracking state: saturating byte index, match flag, value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            in_frame_q <= 1'b0;
            match_q    <= 1'b0;
            val_acc_q  <= '0;
        end else if (active) begin
            idx_q      <= (int'(cur_idx) < MIN_FRAME) ? cur_idx + 1'b1 : cur_idx;
            in_frame_q <= !rx_eof;
            match_q    <= match_n;
            val_acc_q  <= val_n;
        end
    end

    // End-of-frame results, registered with the controls sampled at eof.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_pulse_q <= 1'b0;
            drop_q       <= 1'b0;
            load_q       <= 1'b0;
            value_q      <= '0;
        end else begin
            ctrl_pulse_q <= accept;
            drop_q       <= accept && !pass_all;
            load_q       <= accept && flow_en;
            if (accept) value_q <= val_n;
        end
    end
endmodule

// File: rtl/pause_quanta_timer.sv
// Hold-off timer: loads a quanta count and decrements it once per slot of
// SLOT_CYCLES clocks; drives a registered hold flag while nonzero.
// Assumes a load restarts the slot prescaler from zero.
module pause_quanta_timer
    import flow_pause_pkg::*;
#(
    parameter int SLOT_CYCLES = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [QUANTA_W-1:0] load_val,
    output logic                hold_q
);
    localparam int PW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [PW-1:0] PS_LAST = PW'(SLOT_CYCLES - 1);

    logic [QUANTA_W-1:0] quanta_q;
    logic [QUANTA_W-1:0] quanta_n;
    logic [PW-1:0]       ps_q;
    logic [PW-1:0]       ps_n;

    // Next timer state: reload wins, otherwise count down while nonzero.
    always_comb begin
        quanta_n = quanta_q;
        ps_n     = ps_q;
        if (load) begin
            quanta_n = load_val;
            ps_n     = '0;
        end else if (quanta_q != '0) begin
            if (ps_q == PS_LAST) begin
                ps_n     = '0;
                quanta_n = quanta_q - 1'b1;
            end else begin
                ps_n = ps_q + 1'b1;
            end
        end
    end

    // Timer registers and registered hold output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quanta_q <= '0;
            ps_q     <= '0;
            hold_q   <= 1'b0;
        end else begin
            quanta_q <= quanta_n;
            ps_q     <= ps_n;
            hold_q   <= (quanta_n != '0);
        end
    end
endmodule

// File: rtl/flow_pause_unit.sv
// Top of the PAUSE receiver: parser feeding the hold-off timer.
// Assumes the receive stream is already on the transmit clock.
module flow_pause_unit
    import flow_pause_pkg::*;
#(
    parameter int MIN_FRAME   = 64,
    parameter int SLOT_CYCLES = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic       rx_sof,
    input  logic       rx_eof,
    input  logic [7:0] rx_byte,
    input  logic       rx_crc_ok,
    input  logic       flow_en,
    input  logic       pass_all,
    output logic       tx_hold,
    output logic       ctrl_rx_pulse,
    output logic       frame_discard
);
    logic                load;
    logic [QUANTA_W-1:0] value;
    logic                pulse;
    logic                drop;
    logic                hold;

    pause_frame_parser #(.MIN_FRAME(MIN_FRAME)) u_parser (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_byte(rx_byte), .rx_crc_ok(rx_crc_ok),
        .flow_en(flow_en), .pass_all(pass_all),
        .ctrl_pulse_q(pulse), .drop_q(drop), .load_q(load), .value_q(value)
    );

    pause_quanta_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(value), .hold_q(hold)
    );

    assign tx_hold       = hold;
    assign ctrl_rx_pulse = pulse;
    assign frame_discard = drop;
endmodule

// File: rtl/flow_pause_unit_chk.sv
// Port-level checker for flow_pause_unit, attached by bind below.
module flow_pause_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rx_eof,
    input logic rx_crc_ok,
    input logic flow_en,
    input logic pass_all,
    input logic tx_hold,
    input logic ctrl_rx_pulse,
    input logic frame_discard
);
    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rx_pulse |=> !ctrl_rx_pulse);

    // R5
    pulse_after_good_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rx_pulse |-> $past(rx_valid && rx_eof && rx_crc_ok));

    // R8
    discard_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_discard |-> (ctrl_rx_pulse && !$past(pass_all)));

    // R2
    hold_rise_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_hold) |-> $past(ctrl_rx_pulse));

    // R3
    hold_needs_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_hold) |-> $past(flow_en, 2));
endmodule

bind flow_pause_unit flow_pause_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eof(rx_eof),
    .rx_crc_ok(rx_crc_ok), .flow_en(flow_en), .pass_all(pass_all),
    .tx_hold(tx_hold), .ctrl_rx_pulse(ctrl_rx_pulse), .frame_discard(frame_discard)
);

// File: tb/flow_pause_unit_bench.sv
// Scoreboard bench: the driver queues the expected notify/drop per frame,
// a monitor pops and compares one cycle after each end-of-frame byte.
module flow_pause_unit_bench;
    localparam int SLOT = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic       rx_sof = 1'b0;
    logic       rx_eof = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_crc_ok = 1'b0;
    logic       flow_en = 1'b0;
    logic       pass_all = 1'b0;
    logic       tx_hold;
    logic       ctrl_rx_pulse;
    logic       frame_discard;

    int tests = 0;
    int fails = 0;
    int spurious = 0;
    logic eof_seen = 1'b0;
    logic done = 1'b0;

    typedef struct packed {
        logic pulse;
        logic drop;
    } exp_t;
    exp_t exp_q[$];

    localparam logic [47:0] CTRL_DA = 48'h0180_C200_0001;

    flow_pause_unit u_flow_pause_unit (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_byte(rx_byte), .rx_crc_ok(rx_crc_ok),
        .flow_en(flow_en), .pass_all(pass_all), .tx_hold(tx_hold),
        .ctrl_rx_pulse(ctrl_rx_pulse), .frame_discard(frame_discard)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Driver: send one frame and queue its expected notify/drop result.
    task automatic send_frame(input logic [47:0] da, input logic [15:0] typ,
                              input logic [15:0] op, input logic [15:0] q,
                              input int len, input bit crc, input exp_t e);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid  = 1'b1;
            rx_sof    = (i == 0);
            rx_eof    = (i == len - 1);
            rx_crc_ok = (i == len - 1) ? crc : 1'b0;
            if (i < 6)       rx_byte = da[47 - 8*i -: 8];
            else if (i < 12) rx_byte = 8'hA0 + 8'(i);
            else if (i < 14) rx_byte = typ[15 - 8*(i-12) -: 8];
            else if (i < 16) rx_byte = op[15 - 8*(i-14) -: 8];
            else if (i < 18) rx_byte = q[15 - 8*(i-16) -: 8];
            else             rx_byte = 8'h00;
            if (i == len - 1) exp_q.push_back(e);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0;
    endtask

    // Count cycles of tx_hold, starting one cycle after the notify cycle.
    task automatic measure_hold(input int expv, input string req);
        int n = 0;
        @(negedge clk);
        while (tx_hold && n < 4000) begin
            n++;
            @(negedge clk);
        end
        check(n == expv, req, "hold length", n, expv);
    endtask

    // Monitor: note end-of-frame bytes taken at a rising edge.
    always @(posedge clk) eof_seen <= rx_valid && rx_eof;

    // Monitor: compare notify/drop with the queue one cycle after eof.
    always @(negedge clk) begin
        if (rst_n && eof_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "no expected item", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(ctrl_rx_pulse == e.pulse, "R7", "notify", int'(ctrl_rx_pulse), int'(e.pulse));
                check(frame_discard == e.drop, "R8", "discard", int'(frame_discard), int'(e.drop));
            end
        end else if (rst_n && (ctrl_rx_pulse || frame_discard)) begin
            spurious++;
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!tx_hold && !ctrl_rx_pulse && !frame_discard, "R11", "outputs after reset",
              int'({tx_hold, ctrl_rx_pulse, frame_discard}), 0);

        // R1 R2 R4: good frame, value 2, flow on, pass-all off
        flow_en = 1'b1; pass_all = 1'b0;
        send_frame(CTRL_DA, 16'h8808, 16'h0001, 16'h0002, 64, 1'b1, '{1'b1, 1'b1});
        measure_hold(2 * SLOT, "R2");

        // R3: flow off, notify still given, no hold
        flow_en = 1'b0;
        send_frame(CTRL_DA, 16'h8808, 16'h0001, 16'h0002, 64, 1'b1, '{1'b1, 1'b1});
        measure_hold(0, "R3");

        // R8: pass-all on keeps the frame
        flow_en = 1'b1; pass_all = 1'b1;
        send_frame(CTRL_DA, 16'h8808, 16'h0001, 16'h0001, 64, 1'b1, '{1'b1, 1'b0});
        measure_hold(SLOT, "R8");
        pass_all = 1'b0;

        // R5: bad CRC
        send_frame(CTRL_DA, 16'h8808, 16'h0001, 16'h0002, 64, 1'b0, '{1'b0, 1'b0});
        measure_hold(0, "R5");

        // R6: runt frame, then long frame accepted
        send_frame(CTRL_DA, 16'h8808, 16'h0001, 16'h0002, 63, 1'b1, '{1'b0, 1'b0});
        measure_hold(0, "R6");
        send_frame(CTRL_DA, 16'h8808, 16'h0001, 16'h0001, 100, 1'b1, '{1'b1, 1'b1});
        measure_hold(SLOT, "R6");

        // R1: wrong destination, type and opcode
        send_frame(48'h0180_C200_0002, 16'h8808, 16'h0001, 16'h0002, 64, 1'b1, '{1'b0, 1'b0});
        measure_hold(0, "R1");
        send_frame(CTRL_DA, 16'h0800, 16'h0001, 16'h0002, 64, 1'b1, '{1'b0, 1'b0});
        measure_hold(0, "R1");
        send_frame(CTRL_DA, 16'h8808, 16'h0101, 16'h0002, 64, 1'b1, '{1'b0, 1'b0});
        measure_hold(0, "R1");

        // R9: reload while holding
        send_frame(CTRL_DA, 16'h8808, 16'h0001, 16'h0003, 64, 1'b1, '{1'b1, 1'b1});
        repeat (20) @(negedge clk);
        check(tx_hold == 1'b1, "R4", "hold while timer runs", int'(tx_hold), 1);
        send_frame(CTRL_DA, 16'h8808, 16'h0001, 16'h0001, 64, 1'b1, '{1'b1, 1'b1});
        measure_hold(SLOT, "R9");

        // R10: zero value cancels a running hold
        send_frame(CTRL_DA, 16'h8808, 16'h0001, 16'h0003, 64, 1'b1, '{1'b1, 1'b1});
        repeat (10) @(negedge clk);
        send_frame(CTRL_DA, 16'h8808, 16'h0001, 16'h0000, 64, 1'b1, '{1'b1, 1'b1});
        measure_hold(0, "R10");

        repeat (5) @(negedge clk);
        check(spurious == 0, "R7", "notify/discard outside eof", spurious, 0);
        check(exp_q.size() == 0, "R7", "unconsumed expected items", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule